// File: doc/BRIEF.md
# Selectable Burst Address Sequencer

This block generates the address sequence of a four-beat burst. When an address strobe is taken, the block captures a full starting address. The two low bits of that address set the first beat. Each later beat is produced inside the block whenever the advance input is high. The upper address bits stay as they were captured for the whole burst.

The order of the low bits is chosen by a mode input. In interleaved order, each beat address is the starting low bits XOR the beat number. In linear order, each beat address is the starting low bits plus the beat number, wrapping modulo four. The mode is taken as configuration: it is captured together with the starting address, so moving the pin during a burst does nothing until the next strobe.

A last-beat flag marks the fourth beat of a burst, so a controller can end the burst or begin a new one. The block does not touch the memory or the data path.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is held and after it is released with no other stimulus, addr_o is all zeros and last_beat_o is low.
- R2: A clock edge with load_i high captures start_addr_i and sets the beat count to 0, so after that edge addr_o equals start_addr_i. load_i takes priority over adv_i in the same cycle.
- R3: With interleaved order captured (order_sel_i = 0), each edge with adv_i high and load_i low moves to the next beat, and the low two bits of addr_o equal the starting low bits XOR the beat number. For example, a start of 01 gives 01, 00, 11, 10.
- R4: With linear order captured (order_sel_i = 1), the low two bits of addr_o equal the starting low bits plus the beat number, modulo 4. For example, a start of 01 gives 01, 10, 11, 00.
- R5: An edge with both load_i and adv_i low leaves addr_o and last_beat_o unchanged.
- R6: last_beat_o is high exactly while the beat number is 3, which is the fourth beat after a load.
- R7: Advancing from beat 3 wraps to beat 0. addr_o then returns to the captured starting address and last_beat_o goes low.
- R8: The upper address bits addr_o[ADDR_W-1:2] hold the value captured at the last load. Changes on start_addr_i without load_i have no effect on addr_o.
- R9: A load in the middle of a burst takes the new start at once and resets the beat count to 0.
- R10: order_sel_i is sampled only on a load. Changing it during a burst does not change the order until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Address strobe: capture the start address and mode |
| adv_i | input | 1 | Advance to the next beat |
| order_sel_i | input | 1 | 0 = interleaved order, 1 = linear order |
| start_addr_i | input | ADDR_W | Starting address of the burst |
| addr_o | output | ADDR_W | Current beat address |
| last_beat_o | output | 1 | High on the fourth beat |

## Verification
Full bursts are run from all four starting low-bit values in both orders. A start of 00 cannot tell XOR from add, but starts of 01 and 11 can, so a swapped or mixed-up order map is exposed. Each burst is advanced one step past its fourth beat to check the wrap and the clearing of the last-beat flag. Separate tests cover:
- idle cycles with no advance,
- a strobe arriving in the middle of a burst and together with advance,
- toggling the mode pin during a burst,
- changing the start address without a strobe.

Together these show whether the beat count, the captured mode and the upper bits are truly held by their registers.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    ORD_INTERLEAVE = 1'b0,
    ORD_LINEAR     = 1'b1
  } burst_order_e;
endpackage

// File: rtl/burst_base_reg.sv
module burst_base_reg
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              order_sel_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  output logic [ADDR_W-1:0] base_o,
  output burst_order_e      order_o
);
  // Start address and order are captured only on a strobe.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_o  <= '0;
      order_o <= ORD_INTERLEAVE;
    end else if (load_i) begin
      base_o  <= start_addr_i;
      order_o <= order_sel_i ? ORD_LINEAR : ORD_INTERLEAVE;
    end
  end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             adv_i,
  output logic [CNT_W-1:0] beat_o,
  output logic             last_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] LAST_BEAT = {CNT_W{1'b1}};

  logic step;
  assign step   = adv_i && !load_i;
  assign last_o = (beat_o == LAST_BEAT);
  assign wrap_o = step && last_o;

  // A load clears the count; otherwise an advance steps it, wrapping naturally.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      beat_o <= '0;
    else if (load_i) beat_o <= '0;
    else if (step)   beat_o <= beat_o + 1'b1;
  end
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_seq_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic [CNT_W-1:0] start_lo_i,
  input  logic [CNT_W-1:0] beat_i,
  input  burst_order_e     order_i,
  output logic [CNT_W-1:0] addr_lo_o
);
  function automatic logic [CNT_W-1:0] interleave_addr(
    input logic [CNT_W-1:0] s, input logic [CNT_W-1:0] b);
    return s ^ b;
  endfunction

  function automatic logic [CNT_W-1:0] linear_addr(
    input logic [CNT_W-1:0] s, input logic [CNT_W-1:0] b);
    return s + b;
  endfunction

  always_comb begin
    unique case (order_i)
      ORD_LINEAR:     addr_lo_o = linear_addr(start_lo_i, beat_i);
      default:        addr_lo_o = interleave_addr(start_lo_i, beat_i);
    endcase
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic              order_sel_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_beat_o
);
  localparam int UP_W = ADDR_W - CNT_W;

  logic [ADDR_W-1:0] base_q;
  burst_order_e      order_q;
  logic [CNT_W-1:0]  beat_q;
  logic [CNT_W-1:0]  addr_lo;
  logic              wrap_evt;
  logic              load_evt;
  logic              step_evt;

  assign load_evt = load_i;
  assign step_evt = adv_i && !load_i;

  burst_base_reg #(.ADDR_W(ADDR_W)) base_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (load_i),
    .order_sel_i  (order_sel_i),
    .start_addr_i (start_addr_i),
    .base_o       (base_q),
    .order_o      (order_q)
  );

  burst_beat_ctr #(.CNT_W(CNT_W)) ctr_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load_i),
    .adv_i  (adv_i),
    .beat_o (beat_q),
    .last_o (last_beat_o),
    .wrap_o (wrap_evt)
  );

  burst_order_map #(.CNT_W(CNT_W)) map_i (
    .start_lo_i (base_q[CNT_W-1:0]),
    .beat_i     (beat_q),
    .order_i    (order_q),
    .addr_lo_o  (addr_lo)
  );

  assign addr_o = {base_q[ADDR_W-1:CNT_W], addr_lo};

  if (UP_W < 1) begin : g_bad_width
    initial $error("ADDR_W must exceed CNT_W");
  end
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_evt,
  input logic              step_evt,
  input logic              wrap_evt,
  input logic              order_lin,
  input logic [CNT_W-1:0]  beat_q,
  input logic [ADDR_W-1:0] start_addr_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              last_beat_o
);
  AST_LOAD_TAKES_START: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> addr_o == $past(start_addr_i)); // R2
  AST_INTERLEAVE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && !order_lin) |=>
      (addr_o[CNT_W-1:0] ^ $past(addr_o[CNT_W-1:0])) ==
      ($past(beat_q) ^ CNT_W'($past(beat_q) + 1'b1))); // R3
  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && order_lin) |=>
      addr_o[CNT_W-1:0] == CNT_W'($past(addr_o[CNT_W-1:0]) + 1'b1)); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_evt && !step_evt) |=> ($stable(addr_o) && $stable(last_beat_o))); // R5
  AST_LOAD_NOT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> !last_beat_o); // R6
  AST_WRAP_CLEARS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> !last_beat_o); // R7
  AST_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(addr_o[ADDR_W-1:CNT_W])); // R8
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(order_lin)); // R10
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .load_evt     (load_evt),
  .step_evt     (step_evt),
  .wrap_evt     (wrap_evt),
  .order_lin    (order_q == burst_seq_pkg::ORD_LINEAR),
  .beat_q       (beat_q),
  .start_addr_i (start_addr_i),
  .addr_o       (addr_o),
  .last_beat_o  (last_beat_o)
);

// File: tb/burst_addr_seq_tb_top.sv
module burst_addr_seq_tb_top;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load_i = 1'b0;
  logic          adv_i = 1'b0;
  logic          order_sel_i = 1'b0;
  logic [AW-1:0] start_addr_i = '0;
  logic [AW-1:0] addr_o;
  logic          last_beat_o;

  int n_checks = 0;
  int n_fails  = 0;

  always #10 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .CNT_W(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .adv_i(adv_i),
    .order_sel_i(order_sel_i), .start_addr_i(start_addr_i),
    .addr_o(addr_o), .last_beat_o(last_beat_o)
  );

  // Expected beat address: XOR in interleaved order, add modulo 4 in linear order.
  function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] s, input int b, input bit lin);
    logic [1:0] lo;
    if (lin) lo = 2'((int'(s[1:0]) + b) % 4);
    else     lo = s[1:0] ^ 2'(b);
    return {s[AW-1:2], lo};
  endfunction

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at negedge, sample 1 ns after the following rising edge.
  task automatic step(input bit ld, input bit adv, input bit mode, input logic [AW-1:0] a);
    @(negedge clk);
    load_i = ld; adv_i = adv; order_sel_i = mode; start_addr_i = a;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    check("R1 addr", addr_o, '0);
    check("R1 last", AW'(last_beat_o), '0);
  endtask

  task automatic t_burst(input logic [AW-1:0] s, input bit lin);
    string tag;
    tag = lin ? "R4" : "R3";
    step(1, 0, lin, s);
    check("R2 first beat", addr_o, s);
    check("R6 not last at beat0", AW'(last_beat_o), '0);
    for (int b = 1; b < 4; b++) begin
      step(0, 1, lin, s);
      check(tag, addr_o, beat_addr(s, b, lin));
      check("R6 last flag", AW'(last_beat_o), AW'(b == 3));
    end
    step(0, 1, lin, s);
    check("R7 wrap addr", addr_o, s);
    check("R7 wrap last", AW'(last_beat_o), '0);
  endtask

  task automatic t_hold();
    logic [AW-1:0] s;
    s = 20'hA5A5E;
    step(1, 0, 0, s);
    step(0, 1, 0, s);
    step(0, 1, 0, s);
    step(0, 1, 0, s);
    for (int i = 0; i < 3; i++) begin
      step(0, 0, 0, s);
      check("R5 hold addr", addr_o, beat_addr(s, 3, 0));
      check("R5 hold last", AW'(last_beat_o), AW'(1));
    end
  endtask

  task automatic t_reload();
    step(1, 0, 1, 20'h12341);
    step(0, 1, 1, 20'h12341);
    step(0, 1, 1, 20'h12341);
    step(1, 1, 0, 20'h7F002);
    check("R9 reload addr", addr_o, 20'h7F002);
    check("R2 load beats adv", AW'(last_beat_o), '0);
    step(0, 1, 0, 20'h7F002);
    check("R9 beat1 after reload", addr_o, beat_addr(20'h7F002, 1, 0));
  endtask

  task automatic t_mode_static();
    logic [AW-1:0] s;
    s = 20'h0BEE1;
    step(1, 0, 1, s);
    step(0, 1, 0, s);
    check("R10 linear kept", addr_o, beat_addr(s, 1, 1));
    step(0, 1, 0, s);
    check("R10 linear kept 2", addr_o, beat_addr(s, 2, 1));
  endtask

  task automatic t_upper();
    step(1, 0, 0, 20'h33330);
    step(0, 0, 0, 20'hCCCCF);
    check("R8 idle start change", addr_o, 20'h33330);
    step(0, 1, 1, 20'h55552);
    check("R8 adv start change", addr_o, beat_addr(20'h33330, 1, 0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    for (int lin = 0; lin < 2; lin++)
      for (int lo = 0; lo < 4; lo++)
        t_burst({18'h2C0D5 ^ 18'(lo * 7), 2'(lo)}, bit'(lin));
    t_hold();
    t_reload();
    t_mode_static();
    t_upper();
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end
endmodule